// File: doc/BRIEF.md
# Block Erase Selection Window Timer

This block sits between the command decoder and the erase sequencer of a flash controller. A block-erase command names its first target block with the final write of the command. More blocks may be named by repeating that write while a short acceptance window stays open. The block records every named block in a bitmap. Each new name restarts the window. When the window runs out, the block fires a one-cycle start pulse and hands the sequencer the blocks that are actually erasable, which are the selected blocks with the protected ones masked off.

After the start, the selection is frozen until the sequencer reports completion. A suspend request that arrives while the window is still open closes the window at once and parks the operation. Names that arrive while it is parked are dropped. A resume then launches the erase. If every selected block is protected, the start still happens: the erasable map is empty and a flag tells the sequencer to run a short dummy operation that changes nothing. The block also drives the erase-timer status bit, which is clear while names are accepted and set once erasing has begun.

Top module: `erase_sel_window`

## Requirements
- R1: After reset, `sel_map`, `erase_map`, `start_pulse`, `timer_bit`, `all_prot` and `held` are all 0.
- R2: When idle, a `sel_first` strobe replaces the bitmap with only bit `sel_blk` set and opens the window. `timer_bit` stays 0 while the window is open.
- R3: While the window is open, a `sel_more` or `sel_first` strobe ORs bit `sel_blk` into the bitmap without clearing earlier bits, and restarts the window.
- R4: `start_pulse` rises on the WIN_CYC-th clock edge after the edge that sampled the last select strobe. It stays high for exactly one cycle. A strobe sampled on the expiry edge restarts the window instead of starting the erase.
- R5: From the start pulse onward, `erase_map` equals `sel_map & ~blk_prot`, using `blk_prot` as it was in the cycle before the pulse. `timer_bit` is 1 from the start pulse until completion.
- R6: After the erase has started, select strobes do not change `sel_map`.
- R7: If no selected block is unprotected, the start pulse still occurs with `erase_map` = 0 and `all_prot` = 1. Otherwise `all_prot` is 0.
- R8: `susp_req` while the window is open sets `held` and `timer_bit` on the next edge and produces no start pulse. Select strobes while held are dropped. A `resume_req` while held produces the start pulse on the next edge and clears `held`.
- R9: `erase_done` while erasing clears `sel_map`, `erase_map`, `all_prot` and `timer_bit` on the next edge. When idle, a `sel_more` strobe has no effect.
- R10: `susp_req` when idle or while erasing has no effect. If `susp_req` and a select strobe come in the same cycle while the window is open, the suspend wins and the named block is not added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_first | input | 1 | Strobe: first block of a new erase list |
| sel_more | input | 1 | Strobe: additional block for the list |
| sel_blk | input | BLK_W | Block index carried by either strobe |
| blk_prot | input | NBLK | Protection flag per block, 1 = protected |
| susp_req | input | 1 | Suspend request strobe |
| resume_req | input | 1 | Resume request strobe |
| erase_done | input | 1 | Sequencer reports erase finished |
| start_pulse | output | 1 | One-cycle erase start |
| erase_map | output | NBLK | Blocks the sequencer must erase |
| sel_map | output | NBLK | Blocks selected so far |
| timer_bit | output | 1 | Erase-timer status: 0 = accepting, 1 = erase begun |
| all_prot | output | 1 | Every selected block was protected |
| held | output | 1 | Suspended before the erase began |

## Verification
The bench builds the block with NBLK = 8 and WIN_CYC = 12. A twelve-cycle window lets random gaps between names reach the expiry edge itself, so the retrigger-at-expiry case of R4 comes up often without long waits. Eight blocks with random protection masks make the fully protected case of R7 reachable in random trials as well as in the directed ones.

// File: rtl/erase_sel_pkg.sv
package erase_sel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1,
        ST_HELD = 2'd2,
        ST_RUN  = 2'd3
    } win_state_e;

endpackage

// File: rtl/esw_timer.sv
module esw_timer #(
    parameter int WIN_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WIN_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (load) begin
            d.cnt = LOAD_VAL;
        end else if (run && (q.cnt != '0)) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign expired = run && !load && (q.cnt == '0);

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LOAD_VAL)
        else $error("counter above reload value");

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q.cnt == LOAD_VAL))
        else $error("counter not reloaded by strobe");

endmodule

// File: rtl/esw_collect.sv
module esw_collect #(
    parameter int NBLK = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     set_en,
    input  logic [$clog2(NBLK)-1:0]  set_idx,
    output logic [NBLK-1:0]          map
);
    localparam int BLK_W = $clog2(NBLK);
    localparam logic [NBLK-1:0] ONE = {{(NBLK-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [NBLK-1:0] bits;
    } col_t;

    col_t d, q;
    logic [NBLK-1:0] base;
    logic [NBLK-1:0] hit;

    always_comb begin
        d    = q;
        base = clr ? '0 : q.bits;
        hit  = '0;
        if (set_en) begin
            hit = ONE << set_idx;
        end
        d.bits = base | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign map = q.bits;

    p_grow_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((map & $past(map)) == $past(map)))
        else $error("bitmap lost a bit without clear");

    p_index_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> (int'(set_idx) < NBLK))
        else $error("block index beyond map");

    if (BLK_W < 1) begin : g_bad
        initial $error("NBLK must be at least 2");
    end

endmodule

// File: rtl/esw_ctrl.sv
module esw_ctrl
    import erase_sel_pkg::*;
#(
    parameter int NBLK = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_first,
    input  logic            sel_more,
    input  logic            susp_req,
    input  logic            resume_req,
    input  logic            erase_done,
    input  logic            expired,
    input  logic [NBLK-1:0] sel_map,
    input  logic [NBLK-1:0] blk_prot,
    output logic            tmr_load,
    output logic            tmr_run,
    output logic            col_clr,
    output logic            col_set,
    output logic            start_pulse,
    output logic [NBLK-1:0] erase_map,
    output logic            all_prot,
    output logic            timer_bit,
    output logic            held
);
    typedef struct packed {
        win_state_e      st;
        logic            start;
        logic [NBLK-1:0] emap;
        logic            allp;
    } ctl_t;

    ctl_t d, q;
    logic [NBLK-1:0] usable;
    logic            any_sel;

    always_comb begin
        d        = q;
        d.start  = 1'b0;
        tmr_load = 1'b0;
        col_clr  = 1'b0;
        col_set  = 1'b0;
        any_sel  = sel_first || sel_more;
        usable   = sel_map & ~blk_prot;
        unique case (q.st)
            ST_IDLE: begin
                if (sel_first) begin
                    d.st     = ST_OPEN;
                    col_clr  = 1'b1;
                    col_set  = 1'b1;
                    tmr_load = 1'b1;
                end
            end
            ST_OPEN: begin
                if (susp_req) begin
                    d.st = ST_HELD;
                end else if (any_sel) begin
                    col_set  = 1'b1;
                    tmr_load = 1'b1;
                end else if (expired) begin
                    d.st    = ST_RUN;
                    d.start = 1'b1;
                    d.emap  = usable;
                    d.allp  = (usable == '0);
                end
            end
            ST_HELD: begin
                if (resume_req) begin
                    d.st    = ST_RUN;
                    d.start = 1'b1;
                    d.emap  = usable;
                    d.allp  = (usable == '0);
                end
            end
            ST_RUN: begin
                if (erase_done) begin
                    d.st    = ST_IDLE;
                    d.emap  = '0;
                    d.allp  = 1'b0;
                    col_clr = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, start: 1'b0, emap: '0, allp: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign tmr_run     = (q.st == ST_OPEN);
    assign start_pulse = q.start;
    assign erase_map   = q.emap;
    assign all_prot    = q.allp;
    assign timer_bit   = (q.st == ST_HELD) || (q.st == ST_RUN);
    assign held        = (q.st == ST_HELD);

    p_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse)
        else $error("start pulse longer than one cycle");

    p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> ((erase_map & $past(blk_prot)) == '0))
        else $error("protected block handed to sequencer");

    p_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> timer_bit)
        else $error("timer bit clear at erase start");

    p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_bit && !erase_done) |=> (sel_map == $past(sel_map)))
        else $error("selection changed after erase began");

    p_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (all_prot == (erase_map == '0)))
        else $error("all-protected flag disagrees with map");

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !resume_req) |=> !start_pulse)
        else $error("start while suspended");

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && erase_done) |=> (sel_map == '0 && !timer_bit))
        else $error("completion did not clear selection");

endmodule

// File: rtl/erase_sel_window.sv
module erase_sel_window #(
    parameter int NBLK    = 8,
    parameter int WIN_CYC = 16,
    localparam int BLK_W  = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_first,
    input  logic             sel_more,
    input  logic [BLK_W-1:0] sel_blk,
    input  logic [NBLK-1:0]  blk_prot,
    input  logic             susp_req,
    input  logic             resume_req,
    input  logic             erase_done,
    output logic             start_pulse,
    output logic [NBLK-1:0]  erase_map,
    output logic [NBLK-1:0]  sel_map,
    output logic             timer_bit,
    output logic             all_prot,
    output logic             held
);
    logic tmr_load;
    logic tmr_run;
    logic tmr_exp;
    logic col_clr;
    logic col_set;

    esw_timer #(.WIN_CYC(WIN_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .run     (tmr_run),
        .expired (tmr_exp)
    );

    esw_collect #(.NBLK(NBLK)) u_col (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (col_clr),
        .set_en  (col_set),
        .set_idx (sel_blk),
        .map     (sel_map)
    );

    esw_ctrl #(.NBLK(NBLK)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_first   (sel_first),
        .sel_more    (sel_more),
        .susp_req    (susp_req),
        .resume_req  (resume_req),
        .erase_done  (erase_done),
        .expired     (tmr_exp),
        .sel_map     (sel_map),
        .blk_prot    (blk_prot),
        .tmr_load    (tmr_load),
        .tmr_run     (tmr_run),
        .col_clr     (col_clr),
        .col_set     (col_set),
        .start_pulse (start_pulse),
        .erase_map   (erase_map),
        .all_prot    (all_prot),
        .timer_bit   (timer_bit),
        .held        (held)
    );

endmodule

// File: tb/sim_erase_sel_window.sv
module sim_erase_sel_window;
    localparam int CLK_P = 10;
    localparam int NB    = 8;
    localparam int W     = 12;
    localparam int BW    = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_first = 1'b0;
    logic          sel_more = 1'b0;
    logic [BW-1:0] sel_blk = '0;
    logic [NB-1:0] blk_prot = '0;
    logic          susp_req = 1'b0;
    logic          resume_req = 1'b0;
    logic          erase_done = 1'b0;
    logic          start_pulse;
    logic [NB-1:0] erase_map;
    logic [NB-1:0] sel_map;
    logic          timer_bit;
    logic          all_prot;
    logic          held;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    erase_sel_window #(.NBLK(NB), .WIN_CYC(W)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_first(sel_first), .sel_more(sel_more),
        .sel_blk(sel_blk), .blk_prot(blk_prot), .susp_req(susp_req),
        .resume_req(resume_req), .erase_done(erase_done),
        .start_pulse(start_pulse), .erase_map(erase_map), .sel_map(sel_map),
        .timer_bit(timer_bit), .all_prot(all_prot), .held(held)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [NB-1:0] want_map(logic [NB-1:0] s, logic [NB-1:0] p);
        return s & ~p;
    endfunction

    function automatic logic [NB-1:0] bit_of(int i);
        return NB'(1) << i;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic strobe(bit first, int idx);
        sel_first = first;
        sel_more  = !first;
        sel_blk   = BW'(idx);
        tick();
        sel_first = 1'b0;
        sel_more  = 1'b0;
    endtask

    task automatic pulse_done();
        erase_done = 1'b1;
        tick();
        erase_done = 1'b0;
    endtask

    task automatic wait_start(output int gap);
        gap = 0;
        while (!start_pulse && gap < 4 * W) begin
            tick();
            gap++;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int gap;
        logic [NB-1:0] s;
        void'($urandom(32'h5eed_1234));
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check(sel_map == 0 && erase_map == 0, "R1 maps", int'(sel_map), 0);
        check(!start_pulse && !timer_bit && !all_prot && !held, "R1 flags",
              int'({start_pulse, timer_bit, all_prot, held}), 0);

        // R9 sel_more in idle ignored
        strobe(0, 4);
        check(sel_map == 0, "R9 more in idle", int'(sel_map), 0);

        // R2 first selection
        strobe(1, 2);
        check(sel_map == 8'h04, "R2 first", int'(sel_map), 'h04);
        check(!timer_bit, "R2 timer open", int'(timer_bit), 0);

        // R3 add more
        repeat (3) tick();
        strobe(0, 5);
        check(sel_map == 8'h24, "R3 add", int'(sel_map), 'h24);
        wait_start(gap);
        check(gap == W, "R4 window length", gap, W);
        check(erase_map == 8'h24, "R5 map", int'(erase_map), 'h24);
        check(timer_bit && !all_prot, "R5 timer set", int'({timer_bit, all_prot}), 2);
        tick();
        check(!start_pulse, "R4 one cycle", int'(start_pulse), 0);

        // R6 strobe after start, R10 suspend while running
        strobe(0, 7);
        check(sel_map == 8'h24, "R6 frozen", int'(sel_map), 'h24);
        susp_req = 1'b1; tick(); susp_req = 1'b0;
        check(!held && timer_bit, "R10 suspend in run", int'({held, timer_bit}), 1);

        // R9 done
        pulse_done();
        check(sel_map == 0 && erase_map == 0 && !timer_bit && !all_prot, "R9 clear",
              int'(sel_map), 0);

        // R7 all protected
        blk_prot = 8'hFF;
        strobe(1, 1);
        wait_start(gap);
        check(start_pulse && gap == W, "R7 start anyway", gap, W);
        check(all_prot && erase_map == 0, "R7 flag", int'({all_prot, erase_map}), 'h100);
        pulse_done();
        blk_prot = 8'h00;

        // R8 suspend within window
        strobe(1, 3);
        tick();
        susp_req = 1'b1; tick(); susp_req = 1'b0;
        check(held && timer_bit, "R8 held", int'({held, timer_bit}), 3);
        strobe(0, 6);
        check(sel_map == 8'h08, "R8 add dropped", int'(sel_map), 'h08);
        gap = 0;
        repeat (2 * W) begin
            tick();
            if (start_pulse) gap++;
        end
        check(gap == 0, "R8 no start while held", gap, 0);
        resume_req = 1'b1; tick(); resume_req = 1'b0;
        check(start_pulse && !held, "R8 resume start", int'({start_pulse, held}), 2);
        check(erase_map == 8'h08, "R8 map", int'(erase_map), 'h08);
        pulse_done();

        // R10 suspend and strobe together
        strobe(1, 0);
        sel_more = 1'b1; sel_blk = 3'd4; susp_req = 1'b1;
        tick();
        sel_more = 1'b0; susp_req = 1'b0;
        check(sel_map == 8'h01 && held, "R10 suspend wins", int'(sel_map), 'h01);
        resume_req = 1'b1; tick(); resume_req = 1'b0;
        pulse_done();

        // R10 suspend in idle
        susp_req = 1'b1; tick(); susp_req = 1'b0;
        check(!held && !timer_bit, "R10 suspend idle", int'({held, timer_bit}), 0);

        // random trials
        for (int t = 0; t < 40; t++) begin
            int nadd;
            int early;
            blk_prot = NB'($urandom);
            s = '0;
            early = 0;
            begin
                int b = int'($urandom_range(NB - 1, 0));
                strobe(1, b);
                s = bit_of(b);
            end
            nadd = int'($urandom_range(3, 0));
            for (int a = 0; a < nadd; a++) begin
                int g = int'($urandom_range(W - 1, 1));
                int b = int'($urandom_range(NB - 1, 0));
                repeat (g) begin
                    tick();
                    if (start_pulse) early++;
                end
                strobe($urandom_range(3, 0) == 0, b);
                s = s | bit_of(b);
            end
            check(early == 0, "R4 no early start", early, 0);
            check(sel_map == s, "R3 random map", int'(sel_map), int'(s));
            wait_start(gap);
            check(gap == W, "R4 random window", gap, W);
            check(erase_map == want_map(s, blk_prot), "R5 random erase map",
                  int'(erase_map), int'(want_map(s, blk_prot)));
            check(all_prot == (want_map(s, blk_prot) == 0), "R7 random flag",
                  int'(all_prot), int'(want_map(s, blk_prot) == 0));
            pulse_done();
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule